// File: doc/BRIEF.md
# In-Order Retire Reorder Buffer

This block keeps track of instructions in a small out-of-order core from the moment they are dispatched until they retire. Up to two instructions are allocated per cycle. Each allocation receives a tag from a running counter and occupies one slot of a ring of entries. A slot stores the destination register number, a flag that says whether a register is written at all (stores and branches write none), the instruction index, a done bit and the result value.

Execution units report finished work on a single completion port by broadcasting the tag and result. The matching slot is marked done and captures the value, provided the tag is currently held in the buffer. The retire port releases at most one entry per cycle, and always the oldest one. The oldest entry leaves only after its done bit is set. A younger entry that finishes early waits behind it, so architectural state is updated in program order.

The head and tail are taken from the low bits of the oldest and next tags. A registered occupancy count drives the full and empty flags and the dispatch-ready decision.

Top module: `inorder_rob`

## Requirements
- R1: `disp_ready` is 1 exactly when the free slots (DEPTH minus occupancy) are at least the slots requested: 0 when `disp_valid`=0, 1 when `disp_valid`=1 and `disp_pair`=0, 2 when both are 1. A request is accepted on a clock edge only when `disp_valid` and `disp_ready` are both high.
- R2: The first accepted instruction receives tag `disp_tag0` and the second receives `disp_tag1` = `disp_tag0`+1. Tags advance by the number accepted, wrap modulo 2^TAG_W, and start at 0 after reset.
- R3: Occupancy never exceeds DEPTH. While the buffer is full, `full` is 1, no request is accepted and `disp_tag0` does not move.
- R4: A completion with `cmp_valid`=1 whose tag is resident sets that entry's done bit and stores `cmp_value` at the same clock edge. The stored value is the one later shown on `ret_value`.
- R5: Entries retire in strict allocation order, and `ret_tag` increases by one from each retirement to the next. An entry that completes while an older entry is still not done does not retire.
- R6: When the oldest entry's done bit was set by the completion at edge k, `ret_valid` is 1 after edge k+1, provided all older entries have already retired.
- R7: A retirement presents the entry's `ret_dst`, `ret_has_dst` (0 for entries allocated with no destination) and `ret_pc`, as given at dispatch.
- R8: At most one entry retires per cycle. Several completed entries at the head retire on consecutive cycles.
- R9: A completion whose tag is not resident (older than the head, or not yet allocated) has no effect. A later allocation of that tag does not retire until it is itself completed.
- R10: After reset, `empty`=1, `full`=0, `ret_valid`=0 and `disp_tag0`=0.
- R11: `empty` is 1 exactly when occupancy is 0, and `full` is 1 exactly when occupancy is DEPTH. No retirement follows a cycle in which the buffer was empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request for at least one instruction |
| disp_pair | input | 1 | Request a second instruction in the same cycle |
| disp0_dst | input | REG_W | Destination register of the first instruction |
| disp0_has_dst | input | 1 | First instruction writes a register |
| disp0_pc | input | PC_W | Instruction index of the first instruction |
| disp1_dst | input | REG_W | Destination register of the second instruction |
| disp1_has_dst | input | 1 | Second instruction writes a register |
| disp1_pc | input | PC_W | Instruction index of the second instruction |
| disp_ready | output | 1 | Enough free slots for the current request |
| disp_tag0 | output | TAG_W | Tag given to the first instruction |
| disp_tag1 | output | TAG_W | Tag given to the second instruction |
| cmp_valid | input | 1 | Completion broadcast valid |
| cmp_tag | input | TAG_W | Tag of the completed instruction |
| cmp_value | input | VAL_W | Result of the completed instruction |
| ret_valid | output | 1 | One entry retired |
| ret_tag | output | TAG_W | Tag of the retired entry |
| ret_dst | output | REG_W | Destination of the retired entry |
| ret_has_dst | output | 1 | Retired entry writes a register |
| ret_value | output | VAL_W | Result of the retired entry |
| ret_pc | output | PC_W | Instruction index of the retired entry |
| full | output | 1 | All slots occupied |
| empty | output | 1 | No slot occupied |

## Verification
The bench targets several corner cases:
- A younger entry completes first. A design that retired by done bit rather than by age would release it early and break the tag sequence.
- Completions aimed at stale tags or not-yet-allocated tags. A design without the residency check would set a done bit on a free slot, and the next instruction placed there would retire without ever completing.
- The buffer is filled to the last slot and pair requests are made with one slot free. An off-by-one in the free-slot compare would either overwrite the head or stall needlessly.
- A long random run with a small ring wraps both the slot index and the tag many times. A mistake in the slot/tag alignment or in the wrap arithmetic would show up as wrong retired payloads.

// File: rtl/rob_pkg.sv
package rob_pkg;
  localparam int unsigned DEF_DEPTH = 16;
  localparam int unsigned DEF_TAG_W = 6;
  localparam int unsigned DEF_REG_W = 5;
  localparam int unsigned DEF_VAL_W = 32;
  localparam int unsigned DEF_PC_W  = 16;

  // number of slots a dispatch request asks for
  function automatic logic [1:0] slots_wanted(input logic valid, input logic pair);
    if (!valid) return 2'd0;
    return pair ? 2'd2 : 2'd1;
  endfunction
endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl
  import rob_pkg::*;
#(
  parameter int unsigned DEPTH = DEF_DEPTH,
  parameter int unsigned TAG_W = DEF_TAG_W,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             disp_valid,
  input  logic             disp_pair,
  input  logic             cmp_valid,
  input  logic [TAG_W-1:0] cmp_tag,
  input  logic             head_done,
  output logic [TAG_W-1:0] head_tag,
  output logic [TAG_W-1:0] tail_tag,
  output logic [CNT_W-1:0] occ,
  output logic             disp_ready,
  output logic             alloc0,
  output logic             alloc1,
  output logic             retire,
  output logic             cmp_hit
);
  logic [1:0]       want;
  logic [1:0]       n_in;
  logic [CNT_W-1:0] free_slots;
  logic [TAG_W-1:0] age;

  always_comb begin
    want       = slots_wanted(disp_valid, disp_pair);
    free_slots = CNT_W'(DEPTH) - occ;
    disp_ready = free_slots >= CNT_W'(want);
    alloc0     = disp_valid && disp_ready;
    alloc1     = alloc0 && disp_pair;
    n_in       = alloc0 ? (alloc1 ? 2'd2 : 2'd1) : 2'd0;
    retire     = (occ != '0) && head_done;
    // distance from the oldest tag decides residency
    age        = cmp_tag - head_tag;
    cmp_hit    = cmp_valid && (age < TAG_W'(occ));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_tag <= '0;
      tail_tag <= '0;
      occ      <= '0;
    end else begin
      head_tag <= head_tag + TAG_W'(retire);
      tail_tag <= tail_tag + TAG_W'(n_in);
      occ      <= occ + CNT_W'(n_in) - CNT_W'(retire);
    end
  end
endmodule

// File: rtl/rob_entries.sv
module rob_entries
  import rob_pkg::*;
#(
  parameter int unsigned DEPTH = DEF_DEPTH,
  parameter int unsigned REG_W = DEF_REG_W,
  parameter int unsigned VAL_W = DEF_VAL_W,
  parameter int unsigned PC_W  = DEF_PC_W,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr0,
  input  logic [IDX_W-1:0] slot0,
  input  logic [REG_W-1:0] dst0,
  input  logic             has0,
  input  logic [PC_W-1:0]  pc0,
  input  logic             wr1,
  input  logic [IDX_W-1:0] slot1,
  input  logic [REG_W-1:0] dst1,
  input  logic             has1,
  input  logic [PC_W-1:0]  pc1,
  input  logic             cmp_hit,
  input  logic [IDX_W-1:0] cmp_slot,
  input  logic [VAL_W-1:0] cmp_value,
  input  logic [IDX_W-1:0] head_slot,
  output logic             head_done,
  output logic [REG_W-1:0] head_dst,
  output logic             head_has,
  output logic [PC_W-1:0]  head_pc,
  output logic [VAL_W-1:0] head_value
);
  logic [REG_W-1:0] dst_mem [DEPTH];
  logic             has_mem [DEPTH];
  logic [PC_W-1:0]  pc_mem  [DEPTH];
  logic [VAL_W-1:0] val_mem [DEPTH];
  logic [DEPTH-1:0] done_q;
  logic [DEPTH-1:0] done_clr;
  logic [DEPTH-1:0] done_set;

  // per-slot decode of allocation and completion
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign done_clr[g] = (wr0 && slot0 == IDX_W'(g)) || (wr1 && slot1 == IDX_W'(g));
    assign done_set[g] = cmp_hit && cmp_slot == IDX_W'(g);
  end

  always_ff @(posedge clk) begin
    if (rst) done_q <= '0;
    else     done_q <= (done_q | done_set) & ~done_clr;
  end

  // payload arrays: plain write ports, no reset
  always_ff @(posedge clk) begin
    if (wr0) begin
      dst_mem[slot0] <= dst0;
      has_mem[slot0] <= has0;
      pc_mem[slot0]  <= pc0;
    end
    if (wr1) begin
      dst_mem[slot1] <= dst1;
      has_mem[slot1] <= has1;
      pc_mem[slot1]  <= pc1;
    end
  end

  always_ff @(posedge clk) begin
    if (cmp_hit) val_mem[cmp_slot] <= cmp_value;
  end

  assign head_done  = done_q[head_slot];
  assign head_dst   = dst_mem[head_slot];
  assign head_has   = has_mem[head_slot];
  assign head_pc    = pc_mem[head_slot];
  assign head_value = val_mem[head_slot];
endmodule

// File: rtl/inorder_rob.sv
module inorder_rob
  import rob_pkg::*;
#(
  parameter int unsigned DEPTH = DEF_DEPTH,
  parameter int unsigned TAG_W = DEF_TAG_W,
  parameter int unsigned REG_W = DEF_REG_W,
  parameter int unsigned VAL_W = DEF_VAL_W,
  parameter int unsigned PC_W  = DEF_PC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             disp_valid,
  input  logic             disp_pair,
  input  logic [REG_W-1:0] disp0_dst,
  input  logic             disp0_has_dst,
  input  logic [PC_W-1:0]  disp0_pc,
  input  logic [REG_W-1:0] disp1_dst,
  input  logic             disp1_has_dst,
  input  logic [PC_W-1:0]  disp1_pc,
  output logic             disp_ready,
  output logic [TAG_W-1:0] disp_tag0,
  output logic [TAG_W-1:0] disp_tag1,
  input  logic             cmp_valid,
  input  logic [TAG_W-1:0] cmp_tag,
  input  logic [VAL_W-1:0] cmp_value,
  output logic             ret_valid,
  output logic [TAG_W-1:0] ret_tag,
  output logic [REG_W-1:0] ret_dst,
  output logic             ret_has_dst,
  output logic [VAL_W-1:0] ret_value,
  output logic [PC_W-1:0]  ret_pc,
  output logic             full,
  output logic             empty
);
  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = IDX_W + 1;

  logic [TAG_W-1:0] head_tag;
  logic [TAG_W-1:0] tail_tag;
  logic [CNT_W-1:0] occ;
  logic             alloc0;
  logic             alloc1;
  logic             retire;
  logic             cmp_hit;
  logic             hd_done;
  logic [REG_W-1:0] hd_dst;
  logic             hd_has;
  logic [PC_W-1:0]  hd_pc;
  logic [VAL_W-1:0] hd_value;
  logic [IDX_W-1:0] slot0;

  assign slot0 = tail_tag[IDX_W-1:0];

  rob_ctrl #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .disp_valid (disp_valid),
    .disp_pair  (disp_pair),
    .cmp_valid  (cmp_valid),
    .cmp_tag    (cmp_tag),
    .head_done  (hd_done),
    .head_tag   (head_tag),
    .tail_tag   (tail_tag),
    .occ        (occ),
    .disp_ready (disp_ready),
    .alloc0     (alloc0),
    .alloc1     (alloc1),
    .retire     (retire),
    .cmp_hit    (cmp_hit)
  );

  rob_entries #(.DEPTH(DEPTH), .REG_W(REG_W), .VAL_W(VAL_W), .PC_W(PC_W)) u_entries (
    .clk        (clk),
    .rst        (rst),
    .wr0        (alloc0),
    .slot0      (slot0),
    .dst0       (disp0_dst),
    .has0       (disp0_has_dst),
    .pc0        (disp0_pc),
    .wr1        (alloc1),
    .slot1      (slot0 + IDX_W'(1)),
    .dst1       (disp1_dst),
    .has1       (disp1_has_dst),
    .pc1        (disp1_pc),
    .cmp_hit    (cmp_hit),
    .cmp_slot   (cmp_tag[IDX_W-1:0]),
    .cmp_value  (cmp_value),
    .head_slot  (head_tag[IDX_W-1:0]),
    .head_done  (hd_done),
    .head_dst   (hd_dst),
    .head_has   (hd_has),
    .head_pc    (hd_pc),
    .head_value (hd_value)
  );

  assign disp_tag0 = tail_tag;
  assign disp_tag1 = tail_tag + TAG_W'(1);
  assign full      = (occ == CNT_W'(DEPTH));
  assign empty     = (occ == '0);

  // registered retire port
  always_ff @(posedge clk) begin
    if (rst) ret_valid <= 1'b0;
    else     ret_valid <= retire;
  end

  always_ff @(posedge clk) begin
    if (retire) begin
      ret_tag     <= head_tag;
      ret_dst     <= hd_dst;
      ret_has_dst <= hd_has;
      ret_value   <= hd_value;
      ret_pc      <= hd_pc;
    end
  end
endmodule

// File: rtl/rob_checker.sv
module rob_checker #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned TAG_W = 6,
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             disp_valid,
  input logic             disp_pair,
  input logic             disp_ready,
  input logic             full,
  input logic             empty,
  input logic             ret_valid,
  input logic [TAG_W-1:0] ret_tag,
  input logic [CNT_W-1:0] occ,
  input logic             hd_done
);
  logic             seen;
  logic [TAG_W-1:0] last_tag;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen     <= 1'b0;
      last_tag <= '0;
    end else if (ret_valid) begin
      seen     <= 1'b1;
      last_tag <= ret_tag;
    end
  end

  assert_pair_stall_R1: assert property (@(posedge clk) disable iff (rst)
    disp_valid && disp_pair && (int'(occ) + 2 > int'(DEPTH)) |-> !disp_ready);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    int'(occ) <= int'(DEPTH));

  assert_full_stall_R3: assert property (@(posedge clk) disable iff (rst)
    full && disp_valid |-> !disp_ready);

  assert_tag_order_R5: assert property (@(posedge clk) disable iff (rst)
    ret_valid && seen |-> ret_tag == last_tag + TAG_W'(1));

  assert_retire_done_R6: assert property (@(posedge clk) disable iff (rst)
    ret_valid |-> $past(hd_done));

  assert_empty_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    empty |=> !ret_valid);

  assert_flags_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));
endmodule

bind inorder_rob rob_checker #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .disp_valid (disp_valid),
  .disp_pair  (disp_pair),
  .disp_ready (disp_ready),
  .full       (full),
  .empty      (empty),
  .ret_valid  (ret_valid),
  .ret_tag    (ret_tag),
  .occ        (occ),
  .hd_done    (hd_done)
);

// File: tb/inorder_rob_tb.sv
module inorder_rob_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int TW = 4;
  localparam int RW = 5;
  localparam int VW = 16;
  localparam int PW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic disp_valid = 0, disp_pair = 0;
  logic [RW-1:0] disp0_dst = '0, disp1_dst = '0;
  logic disp0_has_dst = 0, disp1_has_dst = 0;
  logic [PW-1:0] disp0_pc = '0, disp1_pc = '0;
  logic disp_ready;
  logic [TW-1:0] disp_tag0, disp_tag1;
  logic cmp_valid = 0;
  logic [TW-1:0] cmp_tag = '0;
  logic [VW-1:0] cmp_value = '0;
  logic ret_valid;
  logic [TW-1:0] ret_tag;
  logic [RW-1:0] ret_dst;
  logic ret_has_dst;
  logic [VW-1:0] ret_value;
  logic [PW-1:0] ret_pc;
  logic full, empty;

  always #(CLK_PERIOD/2) clk = ~clk;

  inorder_rob #(.DEPTH(DEPTH), .TAG_W(TW), .REG_W(RW), .VAL_W(VW), .PC_W(PW)) u_dut (
    .clk(clk), .rst(rst), .disp_valid(disp_valid), .disp_pair(disp_pair),
    .disp0_dst(disp0_dst), .disp0_has_dst(disp0_has_dst), .disp0_pc(disp0_pc),
    .disp1_dst(disp1_dst), .disp1_has_dst(disp1_has_dst), .disp1_pc(disp1_pc),
    .disp_ready(disp_ready), .disp_tag0(disp_tag0), .disp_tag1(disp_tag1),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_value(cmp_value),
    .ret_valid(ret_valid), .ret_tag(ret_tag), .ret_dst(ret_dst),
    .ret_has_dst(ret_has_dst), .ret_value(ret_value), .ret_pc(ret_pc),
    .full(full), .empty(empty)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // reference model, indexed by tag
  int m_cnt;
  logic [TW-1:0] m_head, m_tail;
  logic m_done [16];
  logic [VW-1:0] m_val [16];
  logic [RW-1:0] m_dst [16];
  logic m_has [16];
  logic [PW-1:0] m_pc [16];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  // one clock: drive at negedge, check after the next posedge at the following negedge
  task automatic cyc(input logic dv, input logic dp,
                     input logic [RW-1:0] a_dst, input logic a_has, input logic [PW-1:0] a_pc,
                     input logic [RW-1:0] b_dst, input logic b_has, input logic [PW-1:0] b_pc,
                     input logic cv, input logic [TW-1:0] ct, input logic [VW-1:0] cval);
    int want;
    bit exp_ready, acc, ret, hit;
    logic [TW-1:0] e_tag;
    logic [RW-1:0] e_dst;
    logic e_has;
    logic [PW-1:0] e_pc;
    logic [VW-1:0] e_val;
    disp_valid = dv; disp_pair = dp;
    disp0_dst = a_dst; disp0_has_dst = a_has; disp0_pc = a_pc;
    disp1_dst = b_dst; disp1_has_dst = b_has; disp1_pc = b_pc;
    cmp_valid = cv; cmp_tag = ct; cmp_value = cval;
    #1;
    want = dv ? (dp ? 2 : 1) : 0;
    exp_ready = (DEPTH - m_cnt) >= want;
    chk(disp_ready == exp_ready, "R1 ready", int'(disp_ready), int'(exp_ready));
    chk(disp_tag0 == m_tail, "R2 tag0", int'(disp_tag0), int'(m_tail));
    chk(disp_tag1 == TW'(m_tail + 4'd1), "R2 tag1", int'(disp_tag1), int'(TW'(m_tail + 4'd1)));
    acc = dv && exp_ready;
    ret = (m_cnt > 0) && m_done[m_head];
    e_tag = m_head; e_dst = m_dst[m_head]; e_has = m_has[m_head];
    e_pc = m_pc[m_head]; e_val = m_val[m_head];
    hit = cv && (int'(TW'(ct - m_head)) < m_cnt);
    if (hit) begin
      m_done[ct] = 1'b1;
      m_val[ct] = cval;
    end
    if (acc) begin
      m_done[m_tail] = 1'b0; m_dst[m_tail] = a_dst; m_has[m_tail] = a_has; m_pc[m_tail] = a_pc;
      if (dp) begin
        m_done[TW'(m_tail + 4'd1)] = 1'b0;
        m_dst[TW'(m_tail + 4'd1)] = b_dst;
        m_has[TW'(m_tail + 4'd1)] = b_has;
        m_pc[TW'(m_tail + 4'd1)] = b_pc;
      end
      m_tail = TW'(m_tail + (dp ? 4'd2 : 4'd1));
      m_cnt += dp ? 2 : 1;
    end
    if (ret) begin
      m_head = TW'(m_head + 4'd1);
      m_cnt -= 1;
    end
    @(negedge clk);
    chk(ret_valid == ret, "R6 ret_valid", int'(ret_valid), int'(ret));
    if (ret && ret_valid) begin
      chk(ret_tag == e_tag, "R5 ret_tag", int'(ret_tag), int'(e_tag));
      chk(ret_value == e_val, "R4 ret_value", int'(ret_value), int'(e_val));
      chk(ret_dst == e_dst, "R7 ret_dst", int'(ret_dst), int'(e_dst));
      chk(ret_has_dst == e_has, "R7 ret_has_dst", int'(ret_has_dst), int'(e_has));
      chk(ret_pc == e_pc, "R7 ret_pc", int'(ret_pc), int'(e_pc));
    end
    chk(full == (m_cnt == DEPTH), "R3 full", int'(full), int'(m_cnt == DEPTH));
    chk(empty == (m_cnt == 0), "R11 empty", int'(empty), int'(m_cnt == 0));
  endtask

  task automatic idle();
    cyc(0, 0, '0, 0, '0, '0, 0, '0, 0, '0, '0);
  endtask
  task automatic disp1(input logic [RW-1:0] d, input logic h, input logic [PW-1:0] p);
    cyc(1, 0, d, h, p, '0, 0, '0, 0, '0, '0);
  endtask
  task automatic disp2(input logic [RW-1:0] d, input logic h, input logic [PW-1:0] p,
                       input logic [RW-1:0] e, input logic g, input logic [PW-1:0] q);
    cyc(1, 1, d, h, p, e, g, q, 0, '0, '0);
  endtask
  task automatic comp(input logic [TW-1:0] t, input logic [VW-1:0] v);
    cyc(0, 0, '0, 0, '0, '0, 0, '0, 1, t, v);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [TW-1:0] t0;
    m_cnt = 0; m_head = '0; m_tail = '0;
    for (int i = 0; i < 16; i++) begin
      m_done[i] = 0; m_val[i] = '0; m_dst[i] = '0; m_has[i] = 0; m_pc[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk(empty == 1'b1, "R10 empty", int'(empty), 1);
    chk(full == 1'b0, "R10 full", int'(full), 0);
    chk(ret_valid == 1'b0, "R10 ret_valid", int'(ret_valid), 0);
    chk(disp_tag0 == '0, "R10 tag", int'(disp_tag0), 0);

    // younger entry completes first and must wait (R5, R6, R8)
    disp2(5'd3, 1, 8'd10, 5'd4, 1, 8'd11);
    disp1(5'd0, 0, 8'd12);
    comp(4'd2, 16'h0222);
    idle(); idle();
    chk(ret_valid == 1'b0, "R5 younger waits", int'(ret_valid), 0);
    comp(4'd1, 16'h0111);
    comp(4'd0, 16'h0100);
    chk(ret_valid == 1'b0, "R6 not same cycle", int'(ret_valid), 0);
    idle();
    chk(ret_valid && ret_tag == 4'd0, "R6 head retires", int'(ret_tag), 0);
    idle();
    chk(ret_valid && ret_tag == 4'd1, "R8 consecutive 1", int'(ret_tag), 1);
    idle();
    chk(ret_valid && ret_tag == 4'd2, "R8 consecutive 2", int'(ret_tag), 2);
    chk(ret_has_dst == 1'b0, "R7 no destination", int'(ret_has_dst), 0);
    idle();
    chk(ret_valid == 1'b0 && empty, "R11 drained", int'(ret_valid), 0);

    // completions to non-resident tags are ignored (R9)
    comp(4'd1, 16'hbeef);
    comp(m_tail, 16'hdead);
    disp1(5'd7, 1, 8'd20);
    for (int k = 0; k < 3; k++) begin
      idle();
      chk(ret_valid == 1'b0, "R9 early completion ignored", int'(ret_valid), 0);
    end
    comp(4'd3, 16'h1234);
    idle();
    chk(ret_valid && ret_value == 16'h1234, "R9 real completion", int'(ret_value), 16'h1234);
    idle();

    // fill to full, then stall (R3, R1)
    disp2(5'd1, 1, 8'd30, 5'd2, 1, 8'd31);
    disp1(5'd3, 1, 8'd32);
    chk(disp_ready == 1'b1, "R1 one free single ok", int'(disp_ready), 1);
    disp_pair = 1; #1;
    chk(disp_ready == 1'b0, "R1 one free pair stalls", int'(disp_ready), 0);
    @(negedge clk);
    disp1(5'd4, 1, 8'd33);
    chk(full == 1'b1, "R3 full", int'(full), 1);
    t0 = disp_tag0;
    disp1(5'd5, 1, 8'd34);
    chk(disp_tag0 == t0, "R3 stall keeps tag", int'(disp_tag0), int'(t0));
    for (int k = 3; k >= 0; k--) comp(TW'(m_head + TW'(k)), VW'(16'h4000 + k));
    repeat (6) idle();

    // random traffic, wrapping slots and tags
    for (int n = 0; n < 4000; n++) begin
      logic dv, dp, cv;
      logic [TW-1:0] ct;
      dv = ($urandom % 4) != 0;
      dp = ($urandom % 2) != 0;
      cv = ($urandom % 3) != 0;
      ct = TW'(m_head + TW'($urandom % 32'(m_cnt + 2)));
      cyc(dv, dp, RW'($urandom), 1'($urandom), PW'($urandom),
          RW'($urandom), 1'($urandom), PW'($urandom), cv, ct, VW'($urandom));
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule